// File: doc/BRIEF.md
# CAN Controller Configuration Register File

This block keeps the main control word of a CAN controller behind a simple memory-mapped CPU port. The port has an address, separate write and read strobes, write data and combinational read data. The same port reaches two storage-only registers that carry their own write locks: a bit-timing word and a test word. Each lock depends on bits of the control word. The block also owns the two DMA-done outputs, one per message interface. Each one rises when a DMA-qualified transfer completes and drops on the next CPU access to that interface's register window.

The initialization bit lives in the protocol clock domain. A CPU write to it crosses a toggle handshake, and the bit reads back only the value the protocol side has actually taken. The protocol engine can force initialization on, and that request wins over a CPU request that arrives at the same time.

Top module: `can_cfg_regs`

## Requirements
- R1: After reset the control word reads 0x0000_0001 (init set, all else 0), the bit-timing and test words read 0, both DMA-done outputs are low and the protocol-side init output is 1.
- R2: Control word at byte address 0x00 has these fields: init bit 0, module interrupt line enable bit 1, status interrupt enable bit 2, error interrupt enable bit 3, retransmission disable bit 5, configuration-change enable bit 6, test enable bit 7, message interrupt line enable bit 17, DMA enable for interface 1 bit 18, DMA enable for interface 2 bit 19. All other bits read 0 and ignore writes.
- R3: The bit-timing word at address 0x04 is BT_W bits wide and takes a write only while configuration-change enable is 1 and the read-back init bit is 1. Otherwise the write leaves it unchanged.
- R4: The test word at address 0x08 is TEST_W bits wide and takes a write only while test enable is 1.
- R5: While an interface's DMA enable bit is 0, its DMA-done output is low from the following cycle on.
- R6: With DMA enable 1, a cycle with that interface's transfer-done and DMA-active both high sets its DMA-done output on the next clock. Transfer-done without DMA-active sets nothing.
- R7: A set DMA-done output clears on the clock after any read or write to its interface window. Interface 1 uses 0x20–0x3F and interface 2 uses 0x40–0x5F. Accesses elsewhere leave it set. A completion in the same cycle as the access keeps it set.
- R8: A written init value is passed to the protocol domain by a toggle handshake. Reads of bit 0 return the previous value until the protocol side has taken the new one, and the protocol-side init output follows the written value.
- R9: While the protocol-domain force request is high, protocol-side init becomes 1 and stays 1, overriding a CPU write of 0 that lands in the same window. The forced value is reflected in CPU reads.
- R10: Reads of any address outside 0x00, 0x04 and 0x08 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | CPU-side active-low reset |
| prot_clk | input | 1 | Protocol-domain clock |
| prot_rst_n | input | 1 | Protocol-domain active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (counts as an access) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| xfer_done | input | N_IF | Per-interface transfer-complete pulse |
| xfer_dma_act | input | N_IF | Per-interface DMA-active qualifier |
| dma_done | output | N_IF | Per-interface DMA-done flag |
| ctrl_word | output | DATA_W | Control word with accepted init in bit 0 |
| bit_timing | output | BT_W | Bit-timing storage |
| test_word | output | TEST_W | Test storage |
| prot_init_set | input | 1 | Protocol-domain force-init request |
| prot_init | output | 1 | Init bit in the protocol domain |

## Verification
The bench goes after the write locks. It tries each locked register both with its enable clear and with init cleared, and a lock that ignored either condition would overwrite the stored value. It reads init one cycle after a change and again after the handshake, which catches a design that echoes the written value at once instead of the accepted one. It checks DMA-done against accesses to the wrong window, against an access in the same cycle as a completion, and against a dropped enable; a wrong decode would clear the flag early or keep it stuck. It also holds the force request over a CPU write of 0, where a design with the wrong priority leaves protocol-side init at 0.

// File: rtl/can_cfg_pkg.sv
package can_cfg_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 32;
    parameter int BT_W   = 16;
    parameter int TEST_W = 8;
    parameter int N_IF   = 2;
    parameter int WIN_LG = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 'h00;
    localparam logic [ADDR_W-1:0] A_BT   = 'h04;
    localparam logic [ADDR_W-1:0] A_TEST = 'h08;

    localparam int B_INIT = 0;
    localparam int B_CCE  = 6;
    localparam int B_TEN  = 7;
    localparam int B_DE0  = 18;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h000E_00EF;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [BT_W-1:0]   bt;
        logic [TEST_W-1:0] tst;
    } cfg_regs_t;
endpackage

// File: rtl/can_cfg_dma_flag.sv
module can_cfg_dma_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic done,
    input  logic act,
    input  logic access,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (!enable)
            flag_d = 1'b0;
        else if (done && act)
            flag_d = 1'b1;
        else if (access)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/can_cfg_init_cdc.sv
module can_cfg_init_cdc (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_val,
    output logic init_rd,
    input  logic prot_clk,
    input  logic prot_rst_n,
    input  logic force_set,
    output logic prot_init
);
    typedef struct packed {
        logic       want;
        logic       dirty;
        logic       busy;
        logic       req_tgl;
        logic       tx_val;
        logic [1:0] ack_s;
        logic       ack_prev;
        logic [1:0] ini_s;
    } cpu_st_t;

    typedef struct packed {
        logic [1:0] req_s;
        logic       req_prev;
        logic       ack_tgl;
        logic       pinit;
    } prot_st_t;

    localparam cpu_st_t CPU_RST = '{want: 1'b1, dirty: 1'b0, busy: 1'b0,
        req_tgl: 1'b0, tx_val: 1'b1, ack_s: 2'b00, ack_prev: 1'b0, ini_s: 2'b11};
    localparam prot_st_t PROT_RST = '{req_s: 2'b00, req_prev: 1'b0,
        ack_tgl: 1'b0, pinit: 1'b1};

    cpu_st_t  c_d, c_q;
    prot_st_t p_d, p_q;

    // CPU side: queue the latest written value, launch one request at a time
    always_comb begin
        c_d          = c_q;
        c_d.ack_s    = {c_q.ack_s[0], p_q.ack_tgl};
        c_d.ack_prev = c_q.ack_s[1];
        c_d.ini_s    = {c_q.ini_s[0], p_q.pinit};
        if (c_q.ack_s[1] != c_q.ack_prev)
            c_d.busy = 1'b0;
        if (c_q.dirty && !c_q.busy) begin
            c_d.tx_val  = c_q.want;
            c_d.req_tgl = ~c_q.req_tgl;
            c_d.busy    = 1'b1;
            c_d.dirty   = 1'b0;
        end
        if (wr_stb) begin
            c_d.want  = wr_val;
            c_d.dirty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CPU_RST;
        else        c_q <= c_d;
    end

    // Protocol side: take the value on a request edge; force request wins
    always_comb begin
        p_d          = p_q;
        p_d.req_s    = {p_q.req_s[0], c_q.req_tgl};
        p_d.req_prev = p_q.req_s[1];
        if (p_q.req_s[1] != p_q.req_prev) begin
            p_d.pinit   = c_q.tx_val;
            p_d.ack_tgl = ~p_q.ack_tgl;
        end
        if (force_set)
            p_d.pinit = 1'b1;
    end

    always_ff @(posedge prot_clk or negedge prot_rst_n) begin
        if (!prot_rst_n) p_q <= PROT_RST;
        else             p_q <= p_d;
    end

    assign init_rd   = c_q.ini_s[1];
    assign prot_init = p_q.pinit;
endmodule

// File: rtl/can_cfg_regs.sv
module can_cfg_regs
    import can_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_clk,
    input  logic              prot_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_IF-1:0]   xfer_done,
    input  logic [N_IF-1:0]   xfer_dma_act,
    output logic [N_IF-1:0]   dma_done,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [BT_W-1:0]   bit_timing,
    output logic [TEST_W-1:0] test_word,
    input  logic              prot_init_set,
    output logic              prot_init
);
    localparam int WIN_HI_W = ADDR_W - WIN_LG;

    cfg_regs_t r_d, r_q;
    logic      init_rd;
    logic      hit_ctrl, hit_bt, hit_test;
    logic      init_wr;
    logic [N_IF-1:0] win_acc;

    assign hit_ctrl = (bus_addr == A_CTRL);
    assign hit_bt   = (bus_addr == A_BT);
    assign hit_test = (bus_addr == A_TEST);
    assign init_wr  = bus_wr && hit_ctrl;

    always_comb begin
        r_d = r_q;
        if (bus_wr && hit_ctrl)
            r_d.ctrl = bus_wdata & CTRL_MASK & ~(DATA_W'(1) << B_INIT);
        if (bus_wr && hit_bt && r_q.ctrl[B_CCE] && init_rd)
            r_d.bt = bus_wdata[BT_W-1:0];
        if (bus_wr && hit_test && r_q.ctrl[B_TEN])
            r_d.tst = bus_wdata[TEST_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)      bus_rdata = ctrl_word;
        else if (hit_bt)   bus_rdata = DATA_W'(r_q.bt);
        else if (hit_test) bus_rdata = DATA_W'(r_q.tst);
    end

    assign ctrl_word  = r_q.ctrl | (DATA_W'(init_rd) << B_INIT);
    assign bit_timing = r_q.bt;
    assign test_word  = r_q.tst;

    can_cfg_init_cdc u_init (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (init_wr),
        .wr_val     (bus_wdata[B_INIT]),
        .init_rd    (init_rd),
        .prot_clk   (prot_clk),
        .prot_rst_n (prot_rst_n),
        .force_set  (prot_init_set),
        .prot_init  (prot_init)
    );

    for (genvar i = 0; i < N_IF; i++) begin : g_if
        assign win_acc[i] = (bus_wr || bus_rd) &&
            (bus_addr[ADDR_W-1:WIN_LG] == WIN_HI_W'(i + 1));

        can_cfg_dma_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (r_q.ctrl[B_DE0+i]),
            .done   (xfer_done[i]),
            .act    (xfer_dma_act[i]),
            .access (win_acc[i]),
            .flag   (dma_done[i])
        );
    end
endmodule

// File: rtl/can_cfg_regs_chk.sv
module can_cfg_regs_chk
    import can_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              prot_clk,
    input logic              prot_rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_IF-1:0]   xfer_done,
    input logic [N_IF-1:0]   xfer_dma_act,
    input logic [N_IF-1:0]   dma_done,
    input logic [DATA_W-1:0] ctrl_word,
    input logic [BT_W-1:0]   bit_timing,
    input logic [TEST_W-1:0] test_word,
    input logic              prot_init_set,
    input logic              prot_init
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> ((bus_rdata & ~CTRL_MASK) == '0));

    p_bt_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_BT && !(ctrl_word[B_CCE] && ctrl_word[B_INIT]))
        |=> $stable(bit_timing));

    p_test_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TEST && !ctrl_word[B_TEN]) |=> $stable(test_word));

    p_force_init_r9: assert property (@(posedge prot_clk) disable iff (!prot_rst_n)
        prot_init_set |=> prot_init);

    for (genvar i = 0; i < N_IF; i++) begin : g_chk
        p_dma_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_word[B_DE0+i] |=> !dma_done[i]);

        p_dma_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dma_done[i]) |-> $past(xfer_done[i] && xfer_dma_act[i]));

        p_dma_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((bus_wr || bus_rd) && bus_addr[ADDR_W-1:WIN_LG] == (ADDR_W-WIN_LG)'(i + 1)
             && !(xfer_done[i] && xfer_dma_act[i])) |=> !dma_done[i]);
    end
endmodule

bind can_cfg_regs can_cfg_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prot_clk      (prot_clk),
    .prot_rst_n    (prot_rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .xfer_done     (xfer_done),
    .xfer_dma_act  (xfer_dma_act),
    .dma_done      (dma_done),
    .ctrl_word     (ctrl_word),
    .bit_timing    (bit_timing),
    .test_word     (test_word),
    .prot_init_set (prot_init_set),
    .prot_init     (prot_init)
);

// File: tb/can_cfg_regs_test.sv
module can_cfg_regs_test;
    import can_cfg_pkg::*;

    logic clk = 1'b0, prot_clk = 1'b0;
    logic rst_n = 1'b0, prot_rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [N_IF-1:0] xfer_done = '0, xfer_dma_act = '0;
    logic [N_IF-1:0] dma_done;
    logic [DATA_W-1:0] ctrl_word;
    logic [BT_W-1:0] bit_timing;
    logic [TEST_W-1:0] test_word;
    logic prot_init_set = 1'b0;
    logic prot_init;

    always #2.5 clk = ~clk;
    always #3.5 prot_clk = ~prot_clk;

    can_cfg_regs uut (.*);

    int n_chk = 0, n_bad = 0;
    logic [DATA_W-1:0] rv;

    typedef struct packed {
        logic [7:0]  addr;
        logic        wr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 32'h0, 32'h0000_0001, 4'd1},  // R1 reset control word
        '{8'h04, 1'b0, 32'h0, 32'h0, 4'd1},          // R1 reset bit timing
        '{8'h08, 1'b0, 32'h0, 32'h0, 4'd1},          // R1 reset test word
        '{8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0, 4'd2},
        '{8'h00, 1'b0, 32'h0, 32'h000E_00EF, 4'd2},  // R2 reserved masked
        '{8'h04, 1'b1, 32'hABCD_1234, 32'h0, 4'd3},
        '{8'h04, 1'b0, 32'h0, 32'h0000_1234, 4'd3},  // R3 unlocked write
        '{8'h08, 1'b1, 32'hFFFF_FFA5, 32'h0, 4'd4},
        '{8'h08, 1'b0, 32'h0, 32'h0000_00A5, 4'd4},  // R4 unlocked write
        '{8'h00, 1'b1, 32'h0000_0001, 32'h0, 4'd2},
        '{8'h00, 1'b0, 32'h0, 32'h0000_0001, 4'd2},
        '{8'h04, 1'b1, 32'h0000_BEEF, 32'h0, 4'd3},
        '{8'h04, 1'b0, 32'h0, 32'h0000_1234, 4'd3},  // R3 locked, no CCE
        '{8'h08, 1'b1, 32'h0000_003C, 32'h0, 4'd4},
        '{8'h08, 1'b0, 32'h0, 32'h0000_00A5, 4'd4},  // R4 locked
        '{8'h00, 1'b1, 32'h0000_0041, 32'h0, 4'd3},
        '{8'h04, 1'b1, 32'h0000_00FF, 32'h0, 4'd3},
        '{8'h04, 1'b0, 32'h0, 32'h0000_00FF, 4'd3},
        '{8'h10, 1'b0, 32'h0, 32'h0, 4'd10},         // R10 unmapped
        '{8'h24, 1'b0, 32'h0, 32'h0, 4'd10},
        '{8'h FC, 1'b0, 32'h0, 32'h0, 4'd10},
        '{8'h00, 1'b1, 32'h0000_0081, 32'h0, 4'd4},
        '{8'h08, 1'b1, 32'h0000_005A, 32'h0, 4'd4},
        '{8'h08, 1'b0, 32'h0, 32'h0000_005A, 4'd4},
        '{8'h00, 1'b1, 32'h0000_0001, 32'h0, 4'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_done(input int i, input logic act);
        @(negedge clk);
        xfer_done[i] = 1'b1; xfer_dma_act[i] = act;
        @(negedge clk);
        xfer_done[i] = 1'b0; xfer_dma_act[i] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1; prot_rst_n = 1'b1;
        idle(2);
        check("R1 dma_done", 32'(dma_done), 32'h0);
        check("R1 prot_init", 32'(prot_init), 32'h1);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) begin
                bus_write(VEC[k].addr, VEC[k].data);
            end else begin
                bus_read(VEC[k].addr, rv);
                check($sformatf("R%0d vec %0d", VEC[k].req, k), rv, VEC[k].exp);
            end
        end
        idle(20);

        // R8: init crossing, old value until accepted
        bus_write(8'h00, 32'h0000_0040);
        bus_read(8'h00, rv);
        check("R8 early read", rv, 32'h0000_0041);
        check("R8 early prot", 32'(prot_init), 32'h1);
        idle(20);
        bus_read(8'h00, rv);
        check("R8 late read", rv, 32'h0000_0040);
        check("R8 late prot", 32'(prot_init), 32'h0);

        // R3: CCE set but init 0 blocks bit timing
        bus_write(8'h04, 32'h0000_7777);
        bus_read(8'h04, rv);
        check("R3 init clear lock", rv, 32'h0000_00FF);

        // R9: force request from the protocol engine
        @(negedge prot_clk); prot_init_set = 1'b1;
        repeat (3) @(negedge prot_clk);
        prot_init_set = 1'b0;
        idle(20);
        bus_read(8'h00, rv);
        check("R9 forced read", rv, 32'h0000_0041);
        check("R9 forced prot", 32'(prot_init), 32'h1);

        @(negedge prot_clk); prot_init_set = 1'b1;
        bus_write(8'h00, 32'h0000_0000);
        idle(20);
        @(negedge prot_clk); prot_init_set = 1'b0;
        idle(20);
        check("R9 priority prot", 32'(prot_init), 32'h1);
        bus_read(8'h00, rv);
        check("R9 priority read", rv, 32'h0000_0001);

        // R5: DMA disabled
        bus_write(8'h00, 32'h0000_0001);
        pulse_done(0, 1'b1);
        check("R5 disabled if1", 32'(dma_done), 32'h0);

        // R6: set needs DMA-active
        bus_write(8'h00, 32'h000C_0001);
        pulse_done(0, 1'b0);
        check("R6 no act", 32'(dma_done), 32'h0);
        pulse_done(0, 1'b1);
        check("R6 set if1", 32'(dma_done), 32'h1);

        // R7: only the own window clears
        bus_read(8'h04, rv);
        check("R7 other reg", 32'(dma_done), 32'h1);
        bus_read(8'h40, rv);
        check("R7 other window", 32'(dma_done), 32'h1);
        bus_read(8'h20, rv);
        check("R7 own window read", 32'(dma_done), 32'h0);
        pulse_done(1, 1'b1);
        check("R6 set if2", 32'(dma_done), 32'h2);
        bus_write(8'h5C, 32'h0);
        check("R7 own window write", 32'(dma_done), 32'h0);

        // R7: completion in the same cycle as the access wins
        @(negedge clk);
        xfer_done[0] = 1'b1; xfer_dma_act[0] = 1'b1;
        bus_addr = 8'h20; bus_rd = 1'b1;
        @(negedge clk);
        xfer_done[0] = 1'b0; xfer_dma_act[0] = 1'b0; bus_rd = 1'b0;
        check("R7 same cycle set", 32'(dma_done), 32'h1);

        // R5: dropping the enable forces the output low
        bus_write(8'h00, 32'h0000_0001);
        idle(1);
        check("R5 enable dropped", 32'(dma_done), 32'h0);

        finish_run();
    end
endmodule